// File: doc/BRIEF.md
# Host-to-Plane Address Translator

This block connects a byte-wide host port to four parallel 8-bit video memory planes. For each host access it works out three things: the offset presented to all planes, a 4-bit write-enable mask that says which planes take the write, and which plane's byte is returned on a read. The host write byte is sent unchanged to every plane. Write enables reach the planes in the same cycle as the address. Read data comes back one clock after the read strobe, with a valid pulse.

There are three addressing modes. In planar mode the host address is used directly and the programmable plane mask decides which planes are written. In odd/even mode the lowest address bit chooses between the even pair of planes and the odd pair. In chain-4 mode the two lowest address bits choose one plane. In both address-selected modes only part of each plane is reachable: half in odd/even mode and a quarter in chain-4 mode. Chain-4 wins when both address-selected modes are enabled.

Top module: `hplane_xlat`

## Requirements
- R1: In chain-4 mode (cfg_chain4=1), a write enables exactly the plane given by host_addr[1:0], with mem_we bit n meaning plane n (00→plane 0, 01→1, 10→2, 11→3), before the plane mask is applied.
- R2: In chain-4 mode, mem_addr equals host_addr with bits 1:0 forced to zero. Four consecutive host bytes therefore share one offset, and the offset advances by four.
- R3: In odd/even mode (cfg_chain4=0, cfg_oe_dis=0), an even host address enables planes 0 and 2 (mask 4'b0101), an odd address enables planes 1 and 3 (mask 4'b1010), and mem_addr is host_addr with bit 0 cleared.
- R4: In planar mode (cfg_chain4=0, cfg_oe_dis=1), mem_addr equals host_addr and the mode-derived mask is 4'b1111.
- R5: mem_we is the bitwise AND of cfg_map_mask and the mode-derived mask while host_wr is high, and it is 4'b0000 while host_wr is low. A write whose resulting mask is zero enables no plane and does nothing else.
- R6: When cfg_chain4=1, the odd/even setting has no effect on the offset, the mask or the read plane.
- R7: In planar mode, a read returns the byte of the plane numbered cfg_rd_map.
- R8: In chain-4 mode, a read returns the plane numbered host_addr[1:0]. In odd/even mode, it returns the plane numbered {cfg_rd_map[1], host_addr[0]}.
- R9: host_rvalid is high in exactly the cycle after a cycle with host_rd high. host_rdata is updated only on a read and otherwise holds its value.
- R10: While rst_n is low, host_rvalid and host_rdata are zero.
- R11: mem_wdata equals host_wdata, and mem_addr and mem_we follow the host inputs in the same cycle with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| cfg_chain4 | input | 1 | Chain-4 addressing enable |
| cfg_oe_dis | input | 1 | Odd/even addressing disable |
| cfg_map_mask | input | 4 | Programmable plane write mask |
| cfg_rd_map | input | 2 | Plane select for planar reads |
| mem_addr | output | ADDR_W | Offset presented to all planes |
| mem_we | output | 4 | Per-plane write enable |
| mem_wdata | output | 8 | Byte written to the enabled planes |
| mem_rdata | input | 32 | Plane read bytes, plane n in bits 8n+7:8n, valid for mem_addr in the same cycle |
| host_rdata | output | 8 | Registered read byte |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |

## Verification
The assertions check on every clock several properties. The write mask never leaves the programmed plane mask. Chain-4 never enables more than one plane, and its offset keeps the low two bits clear. Odd/even writes never reach a plane of the wrong parity. Planar offsets match the host address. The read-valid pulse tracks the strobe. Which plane is actually chosen for each address, and the byte that comes back from it, can only be shown by the bench's scenarios. The same holds for chain-4 priority over odd/even and for a zero-mask write leaving the planes untouched.

// File: rtl/hpx_pkg.sv
package hpx_pkg;

  localparam int NUM_PLANES = 4;
  localparam int PLANE_W    = 8;
  localparam int PSEL_W     = $clog2(NUM_PLANES);

  typedef enum logic [1:0] {
    MODE_PLANAR  = 2'd0,
    MODE_ODDEVEN = 2'd1,
    MODE_CHAIN4  = 2'd2
  } addr_mode_e;

endpackage

// File: rtl/hpx_mode_dec.sv
module hpx_mode_dec
  import hpx_pkg::*;
(
  input  logic       chain4,
  input  logic       oe_dis,
  output addr_mode_e mode
);

  // Chain-4 outranks odd/even when both are requested.
  always_comb begin
    if (chain4)       mode = MODE_CHAIN4;
    else if (!oe_dis) mode = MODE_ODDEVEN;
    else              mode = MODE_PLANAR;
  end

endmodule

// File: rtl/hpx_addr_map.sv
module hpx_addr_map
  import hpx_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  addr_mode_e              mode,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic                    host_wr,
  input  logic [NUM_PLANES-1:0]   map_mask,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [NUM_PLANES-1:0]   mem_we
);

  localparam int LOW_CLR_C4 = PSEL_W;
  localparam int LOW_CLR_OE = 1;

  logic [NUM_PLANES-1:0] mode_mask;

  // Offset: clear the plane-select bits, never shift them out.
  always_comb begin
    mem_addr = host_addr;
    unique case (mode)
      MODE_CHAIN4:  mem_addr[LOW_CLR_C4-1:0] = '0;
      MODE_ODDEVEN: mem_addr[LOW_CLR_OE-1:0] = '0;
      default:      mem_addr = host_addr;
    endcase
  end

  // Per-plane mode mask.
  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    localparam logic [PSEL_W-1:0] PIDX = PSEL_W'(p);
    always_comb begin
      unique case (mode)
        MODE_CHAIN4:  mode_mask[p] = (host_addr[PSEL_W-1:0] == PIDX);
        MODE_ODDEVEN: mode_mask[p] = (host_addr[0] == PIDX[0]);
        default:      mode_mask[p] = 1'b1;
      endcase
    end
    assign mem_we[p] = host_wr & mode_mask[p] & map_mask[p];
  end

endmodule

// File: rtl/hpx_rd_mux.sv
module hpx_rd_mux
  import hpx_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  addr_mode_e                       mode,
  input  logic [PSEL_W-1:0]                addr_lo,
  input  logic [PSEL_W-1:0]                rd_map,
  input  logic                             host_rd,
  input  logic [NUM_PLANES*PLANE_W-1:0]    mem_rdata,
  output logic [PLANE_W-1:0]               host_rdata,
  output logic                             host_rvalid
);

  logic [PLANE_W-1:0] plane_byte [NUM_PLANES];
  logic [PSEL_W-1:0]  rd_sel;
  logic [PLANE_W-1:0] rdata_d, rdata_q;
  logic               rvalid_d, rvalid_q;

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_split
    assign plane_byte[p] = mem_rdata[p*PLANE_W +: PLANE_W];
  end

  always_comb begin
    unique case (mode)
      MODE_CHAIN4:  rd_sel = addr_lo;
      MODE_ODDEVEN: rd_sel = {rd_map[PSEL_W-1], addr_lo[0]};
      default:      rd_sel = rd_map;
    endcase
  end

  // Next state with explicit load enable.
  always_comb begin
    rdata_d  = rdata_q;
    if (host_rd) rdata_d = plane_byte[rd_sel];
    rvalid_d = host_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;

endmodule

// File: rtl/hplane_xlat.sv
module hplane_xlat
  import hpx_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             host_addr,
  input  logic [PLANE_W-1:0]            host_wdata,
  input  logic                          host_rd,
  input  logic                          host_wr,
  input  logic                          cfg_chain4,
  input  logic                          cfg_oe_dis,
  input  logic [NUM_PLANES-1:0]         cfg_map_mask,
  input  logic [PSEL_W-1:0]             cfg_rd_map,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [NUM_PLANES-1:0]         mem_we,
  output logic [PLANE_W-1:0]            mem_wdata,
  input  logic [NUM_PLANES*PLANE_W-1:0] mem_rdata,
  output logic [PLANE_W-1:0]            host_rdata,
  output logic                          host_rvalid
);

  addr_mode_e mode;

  hpx_mode_dec mode_dec_i (
    .chain4 (cfg_chain4),
    .oe_dis (cfg_oe_dis),
    .mode   (mode)
  );

  hpx_addr_map #(.ADDR_W(ADDR_W)) addr_map_i (
    .mode      (mode),
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .map_mask  (cfg_map_mask),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we)
  );

  hpx_rd_mux rd_mux_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .addr_lo     (host_addr[PSEL_W-1:0]),
    .rd_map      (cfg_rd_map),
    .host_rd     (host_rd),
    .mem_rdata   (mem_rdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid)
  );

  assign mem_wdata = host_wdata;

endmodule

// File: rtl/hplane_xlat_chk.sv
module hplane_xlat_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_rd,
  input logic              host_wr,
  input logic              cfg_chain4,
  input logic              cfg_oe_dis,
  input logic [3:0]        cfg_map_mask,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_we,
  input logic [7:0]        host_rdata,
  input logic              host_rvalid
);

  // R5
  we_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we & ~cfg_map_mask) == 4'b0000);

  // R5
  no_we_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |-> (mem_we == 4'b0000));

  // R1
  c4_single_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chain4 |-> $onehot0(mem_we));

  // R2
  c4_offset_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chain4 |-> (mem_addr[1:0] == 2'b00));

  // R3
  oe_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_chain4 && !cfg_oe_dis && host_wr) |->
      ((mem_we & (host_addr[0] ? 4'b0101 : 4'b1010)) == 4'b0000));

  // R4
  planar_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_chain4 && cfg_oe_dis) |-> (mem_addr == host_addr));

  // R9
  rvalid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);

  // R9
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> (!host_rvalid && $stable(host_rdata)));

endmodule

bind hplane_xlat hplane_xlat_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_addr    (host_addr),
  .host_rd      (host_rd),
  .host_wr      (host_wr),
  .cfg_chain4   (cfg_chain4),
  .cfg_oe_dis   (cfg_oe_dis),
  .cfg_map_mask (cfg_map_mask),
  .mem_addr     (mem_addr),
  .mem_we       (mem_we),
  .host_rdata   (host_rdata),
  .host_rvalid  (host_rvalid)
);

// File: tb/hplane_xlat_tb_top.sv
`timescale 1ns/1ps
module hplane_xlat_tb_top;

  localparam int ADDR_W = 16;
  localparam int NVEC   = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] host_addr;
  logic [7:0]        host_wdata;
  logic              host_rd, host_wr;
  logic              cfg_chain4, cfg_oe_dis;
  logic [3:0]        cfg_map_mask;
  logic [1:0]        cfg_rd_map;
  logic [ADDR_W-1:0] mem_addr;
  logic [3:0]        mem_we;
  logic [7:0]        mem_wdata;
  logic [31:0]       mem_rdata;
  logic [7:0]        host_rdata;
  logic              host_rvalid;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  hplane_xlat #(.ADDR_W(ADDR_W)) dut_i (.*);

  // Plane contents as a fixed function of plane and offset.
  function automatic logic [7:0] pat(input int p, input logic [ADDR_W-1:0] off);
    return off[7:0] ^ (8'h11 * 8'(p + 1));
  endfunction

  always_comb
    for (int p = 0; p < 4; p++) mem_rdata[p*8 +: 8] = pat(p, mem_addr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {chain4, oe_dis, map_mask, addr, exp_we, exp_addr}
  localparam logic [41:0] WVEC [NVEC] = '{
    {1'b1, 1'b1, 4'hF, 16'h1234, 4'b0001, 16'h1234},  // R1 R2
    {1'b1, 1'b1, 4'hF, 16'h1235, 4'b0010, 16'h1234},  // R1 R2
    {1'b1, 1'b1, 4'hF, 16'h1236, 4'b0100, 16'h1234},  // R1 R2
    {1'b1, 1'b1, 4'hF, 16'h1237, 4'b1000, 16'h1234},  // R1 R2
    {1'b1, 1'b0, 4'hF, 16'h0005, 4'b0010, 16'h0004},  // R6
    {1'b1, 1'b1, 4'hD, 16'h0009, 4'b0000, 16'h0008},  // R5 zero mask
    {1'b0, 1'b0, 4'hF, 16'h0100, 4'b0101, 16'h0100},  // R3
    {1'b0, 1'b0, 4'hF, 16'h0101, 4'b1010, 16'h0100},  // R3
    {1'b0, 1'b0, 4'h3, 16'h0103, 4'b0010, 16'h0102},  // R3 R5
    {1'b0, 1'b1, 4'h9, 16'hABCD, 4'b1001, 16'hABCD},  // R4 R5
    {1'b0, 1'b1, 4'h0, 16'h0007, 4'b0000, 16'h0007},  // R4 R5
    {1'b0, 1'b1, 4'hF, 16'hFFFF, 4'b1111, 16'hFFFF}   // R4
  };

  task automatic do_read(input string req, input logic c4, input logic oed,
                         input logic [1:0] rmap, input logic [15:0] a,
                         input int exp_p, input logic [15:0] exp_off);
    @(negedge clk);
    cfg_chain4 = c4; cfg_oe_dis = oed; cfg_rd_map = rmap;
    host_addr = a; host_rd = 1'b1; host_wr = 1'b0;
    #1 check({req, " offset"}, 32'(mem_addr), 32'(exp_off));
    @(negedge clk);
    #1;
    check({req, " R9 valid"}, 32'(host_rvalid), 32'd1);
    check({req, " data"}, 32'(host_rdata), 32'(pat(exp_p, exp_off)));
    host_rd = 1'b0;
    host_addr = 16'h00F0;
    @(negedge clk);
    #1;
    check("R9 valid drops", 32'(host_rvalid), 32'd0);
    check("R9 data held", 32'(host_rdata), 32'(pat(exp_p, exp_off)));
  endtask

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    host_addr = '0; host_wdata = '0; host_rd = 1'b0; host_wr = 1'b0;
    cfg_chain4 = 1'b0; cfg_oe_dis = 1'b1; cfg_map_mask = 4'hF; cfg_rd_map = 2'd0;
    repeat (3) @(negedge clk);
    host_rd = 1'b1;
    @(negedge clk);
    #1;
    check("R10 rvalid in reset", 32'(host_rvalid), 32'd0);
    check("R10 rdata in reset", 32'(host_rdata), 32'd0);
    host_rd = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // Vector walk over write mapping.
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {cfg_chain4, cfg_oe_dis, cfg_map_mask, host_addr} = WVEC[i][41:20];
      host_wdata = 8'(8'h5A + i);
      host_wr = 1'b1;
      #1;
      check($sformatf("R1-5 vec%0d we R5", i), 32'(mem_we), 32'(WVEC[i][19:16]));
      check($sformatf("vec%0d offset R2 R3 R4", i), 32'(mem_addr), 32'(WVEC[i][15:0]));
      check("R11 wdata", 32'(mem_wdata), 32'(8'(8'h5A + i)));
    end

    // R5: no strobe, no enables.
    @(negedge clk);
    host_wr = 1'b0; cfg_chain4 = 1'b0; cfg_oe_dis = 1'b1; cfg_map_mask = 4'hF;
    #1 check("R5 idle we", 32'(mem_we), 32'd0);

    // R5: zero-mask write leaves read path untouched.
    do_read("R7 planar", 1'b0, 1'b1, 2'd2, 16'h0040, 2, 16'h0040);
    @(negedge clk);
    cfg_map_mask = 4'h0; host_wr = 1'b1; host_addr = 16'h0040;
    #1 check("R5 zero mask we", 32'(mem_we), 32'd0);
    @(negedge clk);
    host_wr = 1'b0; cfg_map_mask = 4'hF;
    #1 check("R5 rdata unchanged", 32'(host_rdata), 32'(pat(2, 16'h0040)));

    do_read("R7 planar p1", 1'b0, 1'b1, 2'd1, 16'h0023, 1, 16'h0023);
    do_read("R8 chain4", 1'b1, 1'b1, 2'd0, 16'h0043, 3, 16'h0040);
    do_read("R8 oe odd hi", 1'b0, 1'b0, 2'd2, 16'h0011, 3, 16'h0010);
    do_read("R8 oe even lo", 1'b0, 1'b0, 2'd0, 16'h0010, 0, 16'h0010);
    do_read("R6 chain4 over oe", 1'b1, 1'b0, 2'd3, 16'h0022, 2, 16'h0020);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule